// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a single-clock static RAM for a processor's second-level cache. Each word is 64 bits wide. The depth is set by an address-width parameter: 15 bits gives 32K words and 16 bits gives 64K words. The default is kept small so that elaboration stays light.

An access sequence starts when the processor's address strobe or the cache controller's address strobe is sampled high. The block then steps through four beats in the interleaved order a processor expects. It moves to the next beat each time the advance input is high. Writes take effect at the rising clock edge, and a per-byte enable picks which bytes change. Read words pass through an output register. The data bus is three-state and releases one cycle after a deselect.

In a cycle where both strobes are active with chip enable high, the processor strobe wins. A cycle started by the processor strobe is always a read.

Top module: `pbsram_core`

## Requirements
- R1: If `proc_as` is high while `chip_en` is high, the sampled `addr` becomes the burst base, the beat count goes to 0 and that address is read.
- R2: If `ctrl_as` is high while `chip_en` is high (and `proc_as` is not also starting a burst), a burst starts at `addr`. That cycle writes the bytes enabled in `byte_we` if any bit is set, and is a read otherwise.
- R3: If both strobes are high while `chip_en` is high, the processor strobe decides the cycle. The cycle is a read and `byte_we` is ignored.
- R4: If `proc_as` is high while `chip_en` is low, it has no effect. If `ctrl_as` is high while `chip_en` is low, the burst ends (deselect).
- R5: While a burst is active, each cycle with `burst_adv` high adds one (mod 4) to the beat count. The accessed address is the base with its two low bits XORed with the beat count, so beats wrap after the fourth.
- R6: While a burst is active, a cycle with `burst_adv` low and no strobe keeps the current address and repeats the access at it: a read, or a write if any `byte_we` bit is set.
- R7: A write updates only the bytes whose `byte_we` bit is set. Bit i covers data bits 8i+7..8i.
- R8: For a read sampled at edge k, `rd_oe` is high after edge k+1 and `rd_q` carries the word.
- R9: After a cycle with no read (a write, idle or deselect), `rd_oe` is low following the next edge, and `rd_q` floats.
- R10: A strobe that starts a burst while one is already active loads the new base and restarts the beat count at 0.
- R11: After reset, no burst is active and `rd_oe` is low.
- R12: With no burst active and no starting strobe, `burst_adv` and `byte_we` change nothing and no write happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| proc_as | input | 1 | Processor address strobe; needs `chip_en` high |
| ctrl_as | input | 1 | Cache-controller address strobe; deselects when `chip_en` is low |
| chip_en | input | 1 | Chip enable |
| burst_adv | input | 1 | Steps the burst beat |
| addr | input | ADDR_W | Word address loaded at burst start |
| byte_we | input | 8 | Per-byte write enables |
| wr_data | input | 64 | Write data |
| rd_q | output | 64 | Registered read data; high impedance when not driven |
| rd_oe | output | 1 | High while `rd_q` is driven |

## Verification
The whole memory is first loaded through single-beat controller writes. After that, directed sequences cover specific cases:
- full four-beat interleaved bursts, including a wrap past the last beat;
- held beats;
- a restart in the middle of a burst;
- a write attempted on a cycle where both strobes are active;
- a processor strobe while chip enable is low;
- advance and byte enables while no burst is active.

Each of these shows whether the address path, the priority decode or the idle gating is at fault, because a wrong choice leaves a different word, or a different output-enable state, at a known cycle. A seeded random mix of strobes, enables, advances and partial byte masks then exercises how these events interleave. Every cycle is checked against a reference model in the bench.

// File: rtl/pbsram_pkg.sv
package pbsram_pkg;

    localparam int DATA_W = 64;
    localparam int BYTES  = DATA_W / 8;
    localparam int BEAT_W = 2;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_READ,
        ACC_WRITE
    } acc_kind_e;

    typedef enum logic [2:0] {
        EV_IDLE,
        EV_PROC_START,
        EV_CTRL_START,
        EV_ADVANCE,
        EV_HOLD,
        EV_DESELECT
    } burst_ev_e;

    typedef struct packed {
        logic proc_as;
        logic ctrl_as;
        logic ce;
        logic adv;
    } strobe_t;

    // Interleaved beat order: low address bits XOR beat count
    function automatic logic [BEAT_W-1:0] interleave(
        input logic [BEAT_W-1:0] start_lo,
        input logic [BEAT_W-1:0] beat
    );
        return start_lo ^ beat;
    endfunction

    // Processor strobe first, then controller start, then deselect, then burst flow
    function automatic burst_ev_e classify(input strobe_t s, input logic active);
        burst_ev_e ev;
        if (s.proc_as && s.ce)      ev = EV_PROC_START;
        else if (s.ctrl_as && s.ce) ev = EV_CTRL_START;
        else if (s.ctrl_as)         ev = EV_DESELECT;
        else if (!active)           ev = EV_IDLE;
        else if (s.adv)             ev = EV_ADVANCE;
        else                        ev = EV_HOLD;
        return ev;
    endfunction

    function automatic logic [DATA_W-1:0] merge_bytes(
        input logic [DATA_W-1:0] old_w,
        input logic [DATA_W-1:0] new_w,
        input logic [BYTES-1:0]  be
    );
        logic [DATA_W-1:0] r;
        for (int i = 0; i < BYTES; i++) begin
            r[8*i +: 8] = be[i] ? new_w[8*i +: 8] : old_w[8*i +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/pbsram_burst.sv
module pbsram_burst
    import pbsram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  strobe_t              st,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [BYTES-1:0]     be,
    output acc_kind_e            acc_kind,
    output logic [ADDR_W-1:0]    acc_addr
);

    logic                 active;
    logic [ADDR_W-1:0]    base;
    logic [BEAT_W-1:0]    beat;
    logic [BEAT_W-1:0]    next_beat;
    burst_ev_e            ev;
    logic                 starting;

    assign ev       = classify(st, active);
    assign starting = (ev == EV_PROC_START) || (ev == EV_CTRL_START);

    always_comb begin
        unique case (ev)
            EV_PROC_START, EV_CTRL_START: next_beat = '0;
            EV_ADVANCE:                   next_beat = beat + 1'b1;
            default:                      next_beat = beat;
        endcase
    end

    always_comb begin
        if (starting) acc_addr = addr;
        else          acc_addr = {base[ADDR_W-1:BEAT_W], interleave(base[BEAT_W-1:0], next_beat)};
    end

    always_comb begin
        unique case (ev)
            EV_PROC_START:                    acc_kind = ACC_READ;
            EV_CTRL_START, EV_ADVANCE, EV_HOLD: acc_kind = (be != '0) ? ACC_WRITE : ACC_READ;
            default:                          acc_kind = ACC_NONE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            base   <= '0;
            beat   <= '0;
        end else begin
            if (starting) begin
                active <= 1'b1;
                base   <= addr;
            end else if (ev == EV_DESELECT) begin
                active <= 1'b0;
            end
            beat <= next_beat;
        end
    end

    AST_PROC_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (st.proc_as && !st.ce && !st.ctrl_as && !active) |=> !active); // R4
    AST_DESELECT_ENDS: assert property (@(posedge clk) disable iff (rst)
        (st.ctrl_as && !st.ce) |=> !active); // R4
    AST_START_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        (st.ce && (st.proc_as || st.ctrl_as)) |=> (active && beat == '0)); // R10
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (active && !st.ctrl_as && !(st.proc_as && st.ce) && !st.adv)
            |=> ($stable(beat) && $stable(base))); // R6
    AST_BEAT_STEP: assert property (@(posedge clk) disable iff (rst)
        (active && !st.ctrl_as && !(st.proc_as && st.ce) && st.adv)
            |=> (beat == $past(beat) + 2'd1)); // R5
    AST_PROC_PRIORITY: assert property (@(posedge clk) disable iff (rst)
        (st.proc_as && st.ce) |-> (acc_kind == ACC_READ && acc_addr == addr)); // R3

endmodule

// File: rtl/pbsram_array.sv
module pbsram_array
    import pbsram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  acc_kind_e            acc_kind,
    input  logic [ADDR_W-1:0]    acc_addr,
    input  logic [BYTES-1:0]     be,
    input  logic [DATA_W-1:0]    wdata,
    output logic                 rd_req,
    output logic [DATA_W-1:0]    rd_word
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0] rd_addr_q;

    always_ff @(posedge clk) begin
        if (acc_kind == ACC_WRITE) begin
            mem[acc_addr] <= merge_bytes(mem[acc_addr], wdata, be);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_req    <= 1'b0;
            rd_addr_q <= '0;
        end else begin
            rd_req <= (acc_kind == ACC_READ);
            if (acc_kind == ACC_READ) rd_addr_q <= acc_addr;
        end
    end

    assign rd_word = mem[rd_addr_q];

    AST_WRITE_NO_READ: assert property (@(posedge clk) disable iff (rst)
        (acc_kind == ACC_WRITE) |=> !rd_req); // R9

endmodule

// File: rtl/pbsram_outreg.sv
module pbsram_outreg
    import pbsram_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rd_req,
    input  logic [DATA_W-1:0]    rd_word,
    output logic [DATA_W-1:0]    q,
    output logic                 oe
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q  <= '0;
            oe <= 1'b0;
        end else begin
            oe <= rd_req;
            if (rd_req) q <= rd_word;
        end
    end

    AST_FLOAT_AFTER: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> !oe); // R9
    AST_DRIVE_AFTER: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> oe); // R8

endmodule

// File: rtl/pbsram_core.sv
module pbsram_core
    import pbsram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 proc_as,
    input  logic                 ctrl_as,
    input  logic                 chip_en,
    input  logic                 burst_adv,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [7:0]           byte_we,
    input  logic [63:0]          wr_data,
    output logic [63:0]          rd_q,
    output logic                 rd_oe
);

    strobe_t            st;
    acc_kind_e          acc_kind;
    logic [ADDR_W-1:0]  acc_addr;
    logic               rd_req;
    logic [DATA_W-1:0]  rd_word;
    logic [DATA_W-1:0]  q;

    assign st = '{proc_as: proc_as, ctrl_as: ctrl_as, ce: chip_en, adv: burst_adv};

    pbsram_burst #(.ADDR_W(ADDR_W)) i_burst (
        .clk      (clk),
        .rst      (rst),
        .st       (st),
        .addr     (addr),
        .be       (byte_we),
        .acc_kind (acc_kind),
        .acc_addr (acc_addr)
    );

    pbsram_array #(.ADDR_W(ADDR_W)) i_array (
        .clk      (clk),
        .rst      (rst),
        .acc_kind (acc_kind),
        .acc_addr (acc_addr),
        .be       (byte_we),
        .wdata    (wr_data),
        .rd_req   (rd_req),
        .rd_word  (rd_word)
    );

    pbsram_outreg i_out (
        .clk     (clk),
        .rst     (rst),
        .rd_req  (rd_req),
        .rd_word (rd_word),
        .q       (q),
        .oe      (rd_oe)
    );

    assign rd_q = rd_oe ? q : {DATA_W{1'bz}};

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> !rd_oe); // R11

endmodule

// File: tb/test_pbsram_core.sv
module test_pbsram_core;

    localparam int  CLK_P = 10;
    localparam int  AW    = 8;
    localparam int  DEPTH = 1 << AW;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           proc_as = 0, ctrl_as = 0, chip_en = 0, burst_adv = 0;
    logic [AW-1:0]  addr = '0;
    logic [7:0]     byte_we = '0;
    logic [63:0]    wr_data = '0;
    wire  [63:0]    rd_q;
    wire            rd_oe;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #(CLK_P/2) clk = ~clk;

    pbsram_core #(.ADDR_W(AW)) i_pbsram_core (
        .clk(clk), .rst(rst), .proc_as(proc_as), .ctrl_as(ctrl_as),
        .chip_en(chip_en), .burst_adv(burst_adv), .addr(addr),
        .byte_we(byte_we), .wr_data(wr_data), .rd_q(rd_q), .rd_oe(rd_oe)
    );

    // reference model state
    logic [63:0]   mref [DEPTH];
    bit            m_act;
    logic [AW-1:0] m_base;
    logic [1:0]    m_beat;
    bit            p_valid;
    logic [AW-1:0] p_addr;
    string         p_tag;
    bit            e_oe;
    logic [63:0]   e_q;
    string         e_tag;

    function automatic logic [63:0] merge(logic [63:0] o, logic [63:0] n, logic [7:0] be);
        logic [63:0] r;
        for (int i = 0; i < 8; i++) r[8*i +: 8] = be[i] ? n[8*i +: 8] : o[8*i +: 8];
        return r;
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic model_step(bit ps, bit cs, bit ce, bit adv, logic [7:0] be,
                              logic [AW-1:0] a, logic [63:0] wd);
        bit            rd, wr;
        logic [AW-1:0] ax;
        string         tg;
        e_oe  = p_valid;
        e_q   = mref[p_addr];
        e_tag = p_tag;
        rd = 0; wr = 0; ax = '0; tg = "R12";
        if (ps && ce) begin
            tg = m_act ? "R10" : (cs ? "R3" : "R1");
            m_act = 1; m_base = a; m_beat = 0; ax = a; rd = 1;
        end else if (cs && ce) begin
            tg = m_act ? "R10" : "R2";
            m_act = 1; m_base = a; m_beat = 0; ax = a;
            if (be != 0) begin wr = 1; if (be != 8'hFF) tg = "R7"; end else rd = 1;
        end else if (cs) begin
            tg = "R4"; m_act = 0;
        end else if (m_act) begin
            if (adv) begin m_beat = m_beat + 2'd1; tg = "R5"; end else tg = "R6";
            ax = {m_base[AW-1:2], m_base[1:0] ^ m_beat};
            if (be != 0) wr = 1; else rd = 1;
        end
        if (wr) mref[ax] = merge(mref[ax], wd, be);
        p_valid = rd;
        if (rd) begin p_addr = ax; p_tag = tg; end
    endtask

    task automatic cyc(string dtag, bit ps, bit cs, bit ce, bit adv, logic [7:0] be,
                       logic [AW-1:0] a, logic [63:0] wd);
        proc_as = ps; ctrl_as = cs; chip_en = ce; burst_adv = adv;
        byte_we = be; addr = a; wr_data = wd;
        @(posedge clk);
        model_step(ps, cs, ce, adv, be, a, wd);
        @(negedge clk);
        chk({dtag, e_oe ? "/R8 oe" : "/R9 oe"}, {63'd0, rd_oe}, {63'd0, e_oe});
        if (e_oe) chk({dtag, "/", e_tag, " data"}, rd_q, e_q);
    endtask

    task automatic quiet(string dtag, int n);
        cyc(dtag, 0, 1, 0, 0, 8'h00, '0, '0); // deselect
        for (int i = 0; i < n; i++) cyc(dtag, 0, 0, 0, 0, 8'h00, '0, '0);
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        m_act = 0; m_base = '0; m_beat = 0; p_valid = 0; p_addr = '0; p_tag = "R11";
        e_oe = 0; e_q = '0; e_tag = "R11";
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        chk("R11 reset oe", {63'd0, rd_oe}, 64'd0);

        // preload every word through single-beat controller writes
        for (int i = 0; i < DEPTH; i++)
            cyc("R2 preload", 0, 1, 1, 0, 8'hFF, i[AW-1:0], {8'hA5, 24'(i * 7), 32'(i * 32'h01010101)});
        quiet("R9", 2);

        // R1 + R5: processor burst in interleaved order with wrap
        cyc("R1", 1, 0, 1, 0, 8'h00, 8'h12, '0);
        for (int i = 0; i < 5; i++) cyc("R5", 0, 0, 1, 1, 8'h00, 8'h00, '0);
        quiet("R9 deselect float", 2);

        // R3: both strobes with write enables, no write takes place
        cyc("R3", 1, 1, 1, 0, 8'hFF, 8'h40, 64'hDEAD_BEEF_0BAD_F00D);
        quiet("R3", 1);
        cyc("R3 readback", 0, 1, 1, 0, 8'h00, 8'h40, '0);
        quiet("R3", 2);

        // R4 + R12: gated processor strobe, idle advance and write enables
        cyc("R4", 1, 0, 0, 1, 8'h00, 8'h20, '0);
        cyc("R12", 0, 0, 1, 1, 8'hFF, 8'h20, 64'h1111_2222_3333_4444);
        cyc("R12", 0, 0, 0, 0, 8'h0F, 8'h21, 64'h5555_6666_7777_8888);
        cyc("R4 readback", 0, 1, 1, 0, 8'h00, 8'h20, '0);
        cyc("R12 readback", 0, 0, 1, 1, 8'h00, 8'h00, '0);
        quiet("R9", 2);

        // R6: hold keeps the address
        cyc("R6", 1, 0, 1, 0, 8'h00, 8'h33, '0);
        cyc("R6", 0, 0, 1, 1, 8'h00, 8'h00, '0);
        cyc("R6 hold", 0, 0, 1, 0, 8'h00, 8'h00, '0);
        cyc("R6 hold", 0, 0, 1, 0, 8'h00, 8'h00, '0);
        cyc("R6", 0, 0, 1, 1, 8'h00, 8'h00, '0);
        quiet("R9", 2);

        // R7: partial byte write then read
        cyc("R7", 0, 1, 1, 0, 8'h0F, 8'h50, 64'hCAFE_CAFE_1234_5678);
        cyc("R7", 0, 0, 1, 1, 8'hA0, 8'h00, 64'h9999_8888_7777_6666);
        quiet("R7", 1);
        cyc("R7 readback", 1, 0, 1, 0, 8'h00, 8'h50, '0);
        cyc("R7 readback", 0, 0, 1, 1, 8'h00, 8'h00, '0);
        quiet("R7", 2);

        // R10: restart in mid burst
        cyc("R10", 1, 0, 1, 0, 8'h00, 8'h61, '0);
        cyc("R10", 0, 0, 1, 1, 8'h00, 8'h00, '0);
        cyc("R10 restart", 0, 1, 1, 0, 8'h00, 8'h72, '0);
        cyc("R10", 0, 0, 1, 1, 8'h00, 8'h00, '0);
        cyc("R10", 1, 0, 1, 0, 8'h00, 8'h83, '0);
        cyc("R10", 0, 0, 1, 1, 8'h00, 8'h00, '0);
        quiet("R9", 2);

        // random mix
        for (int n = 0; n < 4000; n++) begin
            bit ps, cs, ce, adv;
            logic [7:0] be;
            ps  = ($urandom % 100) < 12;
            cs  = ($urandom % 100) < 12;
            ce  = ($urandom % 100) < 80;
            adv = ($urandom % 100) < 60;
            be  = (($urandom % 100) < 60) ? 8'h00 : 8'($urandom);
            cyc("RND", ps, cs, ce, adv, be, AW'($urandom), {$urandom, $urandom});
        end
        quiet("R9", 2);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule